// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the decode stage of an in-order, two-wide core. The core has two execution pipes that can run different sets of operations. Each cycle the block receives two decoded instruction descriptors in program order. Each descriptor carries an operation kind, a destination register with a byte-lane write mask, and, for the younger instruction, source registers with lane read masks. The block decides whether both instructions issue together, with the older one in the U pipe and the younger one in the V pipe, or whether only the older one issues.

When pairing is refused, the older instruction issues alone to the U pipe. The upstream queue then moves the younger instruction into the older slot for the next cycle. A three-bit reason code reports why pairing was refused. A small state machine holds the registered decision and has three states:

- ST_EMPTY: nothing issues.
- ST_SOLO: the U pipe issues alone.
- ST_DUAL: both pipes issue.

Every cycle the next state is chosen from the current inputs:

- ST_EMPTY when the older slot is invalid.
- ST_DUAL when every pairing rule passes.
- ST_SOLO otherwise.

Any state can move to any state on the next edge.

Top module: `pair_issue_check`

## Requirements
- R1: While rst_n is low and after reset, u_fire and v_fire are 0 and reason is 7 (empty).
- R2: The decision for the inputs present at a rising clock edge appears on u_fire, v_fire and reason just after that edge and holds for one cycle, so back-to-back pairs get independent decisions.
- R3: When old_valid is 0, nothing fires and reason is 7, whatever the younger slot holds.
- R4: When old_valid is 1 and young_valid is 0, only u_fire is 1 and reason is 6.
- R5: Kinds 12 (multiply), 13 (divide), 14 (push-all), 15 (string move), 16 (unpairable FP) and any kind of 17 or above never pair, in either slot. Reason 1.
- R6: A lane mask has bit 0 for the low byte and bit 1 for the high byte; 3 means the full register and 0 means no access. A flow dependence exists when any younger source names the register of the older destination and their lane masks overlap. Pairing is then refused with reason 2.
- R7: An output dependence exists when both destinations name the same register and their lane masks overlap. Pairing is refused with reason 3.
- R8: When both instructions write disjoint, non-zero lane masks of the same register, pairing is refused with reason 4.
- R9: Kinds 5 (shift), 6 (rotate) and 7 (U-only FP) cannot take the V slot. Kinds 8 (jump), 9 (conditional jump), 10 (call) and 11 (FP exchange) cannot take the U slot. A pair that breaks either rule is refused with reason 5.
- R10: Kinds 0 to 4 (move, address computation, simple ALU, push/pop, test/compare) fit either slot. A pair with no refusal cause issues both (u_fire=1, v_fire=1, reason 0).
- R11: When several causes apply, the reported reason is the first in the order unpairable, flow, output, partial, pipe.
- R12: v_fire is never 1 without u_fire. A single issue always goes to the U pipe.
- R13: A younger read of lanes disjoint from the lanes the older instruction writes is not a dependence, and the pair still issues together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| old_valid | input | 1 | Older slot holds an instruction |
| old_kind | input | 5 | Older operation kind |
| old_dst_idx | input | REG_IDX_W | Older destination register |
| old_dst_lanes | input | LANE_W | Older destination lane write mask |
| young_valid | input | 1 | Younger slot holds an instruction |
| young_kind | input | 5 | Younger operation kind |
| young_dst_idx | input | REG_IDX_W | Younger destination register |
| young_dst_lanes | input | LANE_W | Younger destination lane write mask |
| young_src_idx | input | NUM_SRC*REG_IDX_W | Younger source registers, source 0 in the low bits |
| young_src_lanes | input | NUM_SRC*LANE_W | Younger source lane read masks, source 0 in the low bits |
| u_fire | output | 1 | Older instruction issues to the U pipe |
| v_fire | output | 1 | Younger instruction issues to the V pipe |
| reason | output | 3 | Pairing result code (0 to 7) |

## Verification
The bench builds the block with the default parameters: eight registers, two byte lanes and two younger sources. With these values, overlap, disjoint and zero lane masks are all reachable on the same register. A dependence can be placed on either source slot, so the generate loop over sources is exercised at both indices. A sweep over every pair of defined kinds reaches each capability combination. Directed pairs then stack two or more refusal causes to exercise the priority order.

// File: rtl/pair_pkg.sv
package pair_pkg;

    localparam int KIND_W = 5;

    typedef enum logic [KIND_W-1:0] {
        K_MOV      = 5'd0,
        K_LEA      = 5'd1,
        K_ALU      = 5'd2,
        K_PUSHPOP  = 5'd3,
        K_TESTCMP  = 5'd4,
        K_SHIFT    = 5'd5,
        K_ROTATE   = 5'd6,
        K_FP_U     = 5'd7,
        K_JMP      = 5'd8,
        K_JCC      = 5'd9,
        K_CALL     = 5'd10,
        K_FXCH     = 5'd11,
        K_MUL      = 5'd12,
        K_DIV      = 5'd13,
        K_PUSHALL  = 5'd14,
        K_STRMOV   = 5'd15,
        K_FP_SOLO  = 5'd16
    } op_kind_e;

    typedef enum logic [2:0] {
        RSN_PAIRED     = 3'd0,
        RSN_UNPAIRABLE = 3'd1,
        RSN_FLOW       = 3'd2,
        RSN_OUTPUT     = 3'd3,
        RSN_PARTIAL    = 3'd4,
        RSN_PIPE       = 3'd5,
        RSN_NO_YOUNG   = 3'd6,
        RSN_EMPTY      = 3'd7
    } reason_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SOLO  = 2'd1,
        ST_DUAL  = 2'd2
    } issue_state_e;

endpackage

// File: rtl/pair_op_caps.sv
module pair_op_caps
    import pair_pkg::*;
#(
    parameter bit FOR_V_SLOT = 1'b0
) (
    input  logic [KIND_W-1:0] kind,
    output logic              slot_ok,
    output logic              never_pair
);

    logic any_pipe;
    logic u_only;
    logic v_only;

    always_comb begin
        any_pipe   = 1'b0;
        u_only     = 1'b0;
        v_only     = 1'b0;
        never_pair = 1'b0;
        case (kind)
            K_MOV, K_LEA, K_ALU, K_PUSHPOP, K_TESTCMP: any_pipe = 1'b1;
            K_SHIFT, K_ROTATE, K_FP_U:                 u_only   = 1'b1;
            K_JMP, K_JCC, K_CALL, K_FXCH:              v_only   = 1'b1;
            default:                                   never_pair = 1'b1;
        endcase
    end

    generate
        if (FOR_V_SLOT) begin : g_v_slot
            assign slot_ok = any_pipe | v_only;
        end else begin : g_u_slot
            assign slot_ok = any_pipe | u_only;
        end
    endgenerate

endmodule

// File: rtl/pair_dep_scan.sv
module pair_dep_scan #(
    parameter int REG_IDX_W = 3,
    parameter int LANE_W    = 2,
    parameter int NUM_SRC   = 2
) (
    input  logic [REG_IDX_W-1:0]         old_dst_idx,
    input  logic [LANE_W-1:0]            old_dst_lanes,
    input  logic [REG_IDX_W-1:0]         young_dst_idx,
    input  logic [LANE_W-1:0]            young_dst_lanes,
    input  logic [NUM_SRC*REG_IDX_W-1:0] young_src_idx,
    input  logic [NUM_SRC*LANE_W-1:0]    young_src_lanes,
    output logic                         flow_dep,
    output logic                         out_dep,
    output logic                         part_dep
);

    logic [NUM_SRC-1:0] src_hit;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            logic [REG_IDX_W-1:0] idx_s;
            logic [LANE_W-1:0]    lanes_s;
            assign idx_s   = young_src_idx[s*REG_IDX_W +: REG_IDX_W];
            assign lanes_s = young_src_lanes[s*LANE_W +: LANE_W];
            assign src_hit[s] = (idx_s == old_dst_idx) && ((lanes_s & old_dst_lanes) != '0);
        end
    endgenerate

    logic same_dst;
    logic both_write;
    logic lane_overlap;

    always_comb begin
        same_dst     = (old_dst_idx == young_dst_idx);
        both_write   = (old_dst_lanes != '0) && (young_dst_lanes != '0);
        lane_overlap = ((old_dst_lanes & young_dst_lanes) != '0);
        flow_dep     = |src_hit;
        out_dep      = same_dst && lane_overlap;
        part_dep     = same_dst && both_write && !lane_overlap;
    end

endmodule

// File: rtl/pair_decide.sv
module pair_decide
    import pair_pkg::*;
(
    input  logic         old_valid,
    input  logic         young_valid,
    input  logic         old_never,
    input  logic         young_never,
    input  logic         old_fits_u,
    input  logic         young_fits_v,
    input  logic         flow_dep,
    input  logic         out_dep,
    input  logic         part_dep,
    output reason_e      nxt_reason,
    output issue_state_e nxt_state
);

    always_comb begin
        nxt_state  = ST_SOLO;
        nxt_reason = RSN_PAIRED;
        if (!old_valid) begin
            nxt_state  = ST_EMPTY;
            nxt_reason = RSN_EMPTY;
        end else if (!young_valid) begin
            nxt_reason = RSN_NO_YOUNG;
        end else if (old_never || young_never) begin
            nxt_reason = RSN_UNPAIRABLE;
        end else if (flow_dep) begin
            nxt_reason = RSN_FLOW;
        end else if (out_dep) begin
            nxt_reason = RSN_OUTPUT;
        end else if (part_dep) begin
            nxt_reason = RSN_PARTIAL;
        end else if (!old_fits_u || !young_fits_v) begin
            nxt_reason = RSN_PIPE;
        end else begin
            nxt_state  = ST_DUAL;
            nxt_reason = RSN_PAIRED;
        end
    end

endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
    import pair_pkg::*;
#(
    parameter int REG_IDX_W = 3,
    parameter int LANE_W    = 2,
    parameter int NUM_SRC   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         old_valid,
    input  logic [KIND_W-1:0]            old_kind,
    input  logic [REG_IDX_W-1:0]         old_dst_idx,
    input  logic [LANE_W-1:0]            old_dst_lanes,
    input  logic                         young_valid,
    input  logic [KIND_W-1:0]            young_kind,
    input  logic [REG_IDX_W-1:0]         young_dst_idx,
    input  logic [LANE_W-1:0]            young_dst_lanes,
    input  logic [NUM_SRC*REG_IDX_W-1:0] young_src_idx,
    input  logic [NUM_SRC*LANE_W-1:0]    young_src_lanes,
    output logic                         u_fire,
    output logic                         v_fire,
    output logic [2:0]                   reason
);

    logic old_fits_u, old_never;
    logic young_fits_v, young_never;
    logic flow_dep, out_dep, part_dep;
    reason_e      nxt_reason, reason_q;
    issue_state_e nxt_state, state_q;

    pair_op_caps #(.FOR_V_SLOT(1'b0)) u_old_caps (
        .kind       (old_kind),
        .slot_ok    (old_fits_u),
        .never_pair (old_never)
    );

    pair_op_caps #(.FOR_V_SLOT(1'b1)) u_young_caps (
        .kind       (young_kind),
        .slot_ok    (young_fits_v),
        .never_pair (young_never)
    );

    pair_dep_scan #(
        .REG_IDX_W (REG_IDX_W),
        .LANE_W    (LANE_W),
        .NUM_SRC   (NUM_SRC)
    ) u_dep (
        .old_dst_idx     (old_dst_idx),
        .old_dst_lanes   (old_dst_lanes),
        .young_dst_idx   (young_dst_idx),
        .young_dst_lanes (young_dst_lanes),
        .young_src_idx   (young_src_idx),
        .young_src_lanes (young_src_lanes),
        .flow_dep        (flow_dep),
        .out_dep         (out_dep),
        .part_dep        (part_dep)
    );

    pair_decide u_decide (
        .old_valid    (old_valid),
        .young_valid  (young_valid),
        .old_never    (old_never),
        .young_never  (young_never),
        .old_fits_u   (old_fits_u),
        .young_fits_v (young_fits_v),
        .flow_dep     (flow_dep),
        .out_dep      (out_dep),
        .part_dep     (part_dep),
        .nxt_reason   (nxt_reason),
        .nxt_state    (nxt_state)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            reason_q <= RSN_EMPTY;
        end else begin
            state_q  <= nxt_state;
            reason_q <= nxt_reason;
        end
    end

    // outputs from state
    always_comb begin
        u_fire = 1'b0;
        v_fire = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                u_fire = 1'b0;
                v_fire = 1'b0;
            end
            ST_SOLO: begin
                u_fire = 1'b1;
                v_fire = 1'b0;
            end
            ST_DUAL: begin
                u_fire = 1'b1;
                v_fire = 1'b1;
            end
            default: begin
                u_fire = 1'b0;
                v_fire = 1'b0;
            end
        endcase
        reason = reason_q;
    end

    // R12
    v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_fire |-> u_fire);

    // R5
    never_blocks_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && young_valid && (old_never || young_never)) |=> (!v_fire && reason == RSN_UNPAIRABLE));

    // R6
    flow_blocks_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && young_valid && flow_dep) |=> !v_fire);

    // R3
    empty_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !old_valid |=> (!u_fire && reason == RSN_EMPTY));

    // R4
    lone_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && !young_valid) |=> (u_fire && !v_fire));

endmodule

// File: tb/pair_issue_check_bench.sv
module pair_issue_check_bench;

    localparam int RW = 3;
    localparam int LW = 2;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic old_valid = 1'b0;
    logic [4:0] old_kind = '0;
    logic [RW-1:0] old_dst_idx = '0;
    logic [LW-1:0] old_dst_lanes = '0;
    logic young_valid = 1'b0;
    logic [4:0] young_kind = '0;
    logic [RW-1:0] young_dst_idx = '0;
    logic [LW-1:0] young_dst_lanes = '0;
    logic [NS*RW-1:0] young_src_idx = '0;
    logic [NS*LW-1:0] young_src_lanes = '0;
    logic u_fire, v_fire;
    logic [2:0] reason;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic       u;
        logic       v;
        logic [2:0] r;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    pair_issue_check #(.REG_IDX_W(RW), .LANE_W(LW), .NUM_SRC(NS)) u_pair_issue_check (
        .clk(clk), .rst_n(rst_n),
        .old_valid(old_valid), .old_kind(old_kind),
        .old_dst_idx(old_dst_idx), .old_dst_lanes(old_dst_lanes),
        .young_valid(young_valid), .young_kind(young_kind),
        .young_dst_idx(young_dst_idx), .young_dst_lanes(young_dst_lanes),
        .young_src_idx(young_src_idx), .young_src_lanes(young_src_lanes),
        .u_fire(u_fire), .v_fire(v_fire), .reason(reason)
    );

    function automatic bit k_never(input int k);
        return k >= 12;
    endfunction
    function automatic bit k_in_u(input int k);
        return k <= 7;
    endfunction
    function automatic bit k_in_v(input int k);
        return (k <= 4) || (k >= 8 && k <= 11);
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, got, want);
        end
    endtask

    task automatic send(input bit ov, input int ok, input int od, input int odl,
                        input bit yv, input int yk, input int yd, input int ydl,
                        input int s0, input int s0l, input int s1, input int s1l,
                        input string tag);
        exp_t e;
        bit flow, outd, part;
        @(negedge clk);
        old_valid = ov;  old_kind = ok[4:0];
        old_dst_idx = od[RW-1:0]; old_dst_lanes = odl[LW-1:0];
        young_valid = yv; young_kind = yk[4:0];
        young_dst_idx = yd[RW-1:0]; young_dst_lanes = ydl[LW-1:0];
        young_src_idx = {s1[RW-1:0], s0[RW-1:0]};
        young_src_lanes = {s1l[LW-1:0], s0l[LW-1:0]};
        flow = ((s0 == od) && ((s0l & odl) != 0)) || ((s1 == od) && ((s1l & odl) != 0));
        outd = (od == yd) && ((odl & ydl) != 0);
        part = (od == yd) && (odl != 0) && (ydl != 0) && ((odl & ydl) == 0);
        e.tag = tag;
        e.u = 1'b1; e.v = 1'b0;
        if (!ov) begin e.u = 1'b0; e.r = 3'd7; end
        else if (!yv) e.r = 3'd6;
        else if (k_never(ok) || k_never(yk)) e.r = 3'd1;
        else if (flow) e.r = 3'd2;
        else if (outd) e.r = 3'd3;
        else if (part) e.r = 3'd4;
        else if (!k_in_u(ok) || !k_in_v(yk)) e.r = 3'd5;
        else begin e.v = 1'b1; e.r = 3'd0; end
        sb.push_back(e);
    endtask

    // monitor: pop and compare after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && sb.size() > 0) begin
                e = sb.pop_front();
                check({e.tag, " reason"}, reason, e.r);
                check({e.tag, " u_fire"}, {2'b0, u_fire}, {2'b0, e.u});
                check({e.tag, " v_fire"}, {2'b0, v_fire}, {2'b0, e.v});
                // R12 single issue uses U only
                check("R12 v without u", {2'b0, v_fire & ~u_fire}, 3'd0);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset reason", reason, 3'd7);
        check("R1 reset u_fire", {2'b0, u_fire}, 3'd0);
        check("R1 reset v_fire", {2'b0, v_fire}, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after reset reason", reason, 3'd7);

        // R3 empty older slot, younger ignored
        send(0, 0, 1, 3, 1, 0, 2, 3, 3, 3, 4, 3, "R3");
        send(0, 12, 1, 3, 0, 0, 2, 3, 3, 3, 4, 3, "R3");
        // R4 older alone
        send(1, 5, 1, 3, 0, 0, 2, 3, 3, 3, 4, 3, "R4");
        send(1, 8, 1, 3, 0, 12, 1, 3, 1, 3, 1, 3, "R4");
        // R10 plain pairs
        send(1, 0, 1, 3, 1, 2, 2, 3, 3, 3, 4, 3, "R10");
        send(1, 5, 1, 3, 1, 9, 0, 0, 3, 3, 4, 3, "R10");
        // R6 flow via source 0 and source 1
        send(1, 0, 2, 3, 1, 2, 5, 3, 2, 1, 4, 3, "R6 src0");
        send(1, 0, 2, 2, 1, 2, 5, 3, 4, 3, 2, 2, "R6 src1");
        send(1, 0, 2, 0, 1, 2, 5, 3, 2, 3, 2, 3, "R6 no write");
        // R13 disjoint lane read
        send(1, 0, 2, 1, 1, 2, 5, 3, 2, 2, 6, 3, "R13");
        // R7 output
        send(1, 1, 3, 3, 1, 2, 3, 3, 0, 3, 1, 3, "R7 full");
        send(1, 1, 3, 3, 1, 2, 3, 1, 0, 3, 1, 3, "R7 low");
        send(1, 1, 3, 3, 1, 2, 3, 0, 0, 3, 1, 3, "R7 no young write");
        // R8 partial
        send(1, 0, 4, 1, 1, 0, 4, 2, 0, 3, 1, 3, "R8");
        // R9 pipe capability
        send(1, 8, 1, 3, 1, 0, 2, 3, 3, 3, 4, 3, "R9 older v-only");
        send(1, 0, 1, 3, 1, 6, 2, 3, 3, 3, 4, 3, "R9 younger u-only");
        send(1, 11, 1, 3, 1, 7, 2, 3, 3, 3, 4, 3, "R9 both wrong");
        // R5 undefined kinds
        send(1, 20, 1, 3, 1, 0, 2, 3, 3, 3, 4, 3, "R5 undefined older");
        send(1, 0, 1, 3, 1, 31, 2, 3, 3, 3, 4, 3, "R5 undefined younger");
        // R11 priority stacks
        send(1, 12, 2, 3, 1, 0, 2, 3, 2, 3, 4, 3, "R11 never over flow");
        send(1, 0, 2, 3, 1, 0, 2, 3, 2, 3, 4, 3, "R11 flow over output");
        send(1, 8, 3, 3, 1, 0, 3, 3, 0, 3, 1, 3, "R11 output over pipe");
        send(1, 0, 4, 1, 1, 5, 4, 2, 0, 3, 1, 3, "R11 partial over pipe");
        // R2 back-to-back alternation
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) send(1, 2, 1, 3, 1, 2, 2, 3, 3, 3, 4, 3, "R2");
            else            send(1, 2, 1, 3, 1, 2, 1, 3, 3, 3, 4, 3, "R2");
        end
        // R5 R9 R10 sweep of all defined kinds
        for (int a = 0; a < 17; a++)
            for (int b = 0; b < 17; b++)
                send(1, a, 1, 3, 1, b, 2, 3, 3, 3, 4, 3, "R5 R9 R10 sweep");

        @(negedge clk);
        old_valid = 1'b0;
        young_valid = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule